// File: doc/BRIEF.md
# Directional Byte Mailbox Buffer

This block is a single byte-wide first-in-first-out buffer whose depth is a power of two. Three static settings fix how it behaves: whether the slot is in use at all, whether it faces the host or belongs to an on-chip peripheral, and whether it carries data into the chip (input role) or out of it (output role). A host-facing input buffer is filled by the host and drained by the on-chip consumer. A host-facing output buffer is filled by the on-chip producer and drained by the host. A peripheral-owned buffer has both ends on the internal side.

Host traffic arrives as mailbox transactions. When a transaction opens, the block freezes a byte allowance and reports it to the transport at once. For a push the allowance is the free space, and for a pull it is the stored data. Host bytes beyond that allowance are dropped, even if room or data appears while the transaction is still open. A transaction in the wrong direction, or one aimed at a peripheral-owned or unused slot, gets an allowance of zero. A 32-bit status word gives the three settings, a sticky error bit and a level. The level is free space for input buffers and stored bytes for output buffers. A control write can flush the contents and always clears the sticky error bit.

Top module: `mbx_buffer`

## Requirements
- R1: After reset the buffer is empty, the sticky error bit is 0, `txn_open` is 0 and `txn_budget` is 0.
- R2: `status` carries active in bit 0, host-managed in bit 1, input role in bit 2, sticky error in bit 3 and the 16-bit level in bits 31:16. All other bits read 0.
- R3: The level in `status` equals the free space (DEPTH minus stored bytes) for an input buffer and the stored byte count for an output buffer.
- R4: A push transaction (`txn_start` with `txn_push`=1) on an active, host-managed input buffer sets `txn_budget` to the free space seen at the start edge. The new value is visible from the following cycle. Until the next start, no more host bytes than that budget are stored, even if the consumer frees space in the meantime.
- R5: A pull transaction (`txn_push`=0) on an active, host-managed output buffer sets `txn_budget` to the stored count seen at the start edge. Each accepted `host_rd_en` removes one byte, and `host_rd_valid` with its data appears in the next cycle. Bytes that the producer adds during the transaction are not returned by it.
- R6: A transaction in the wrong direction for the role, or one on a peripheral-managed or inactive buffer, gets a budget of 0. Its host accesses change neither the contents nor the level.
- R7: Bytes leave the buffer in the order they were stored, on both the host port and the internal port.
- R8: A control write with bit 15 set, on an active buffer, empties the buffer and zeroes the remaining transaction allowance. An internal or host access in the same cycle is dropped.
- R9: An inactive buffer ignores internal accesses and control writes. Its level keeps its reset value.
- R10: On an active peripheral-managed buffer, an internal write while full or an internal read while empty sets the sticky error bit. The bit stays set until a control write. A host-managed buffer never sets it.
- R11: Any control write to an active buffer clears the sticky error bit. Without bit 15 it leaves the contents untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_active | input | 1 | Slot is in use (static) |
| cfg_host_mgd | input | 1 | Host owns one end (static) |
| cfg_input | input | 1 | Input role when 1, output role when 0 (static) |
| txn_start | input | 1 | Opens a host transaction and latches the allowance |
| txn_push | input | 1 | Direction of the opening transaction: 1 push, 0 pull |
| txn_stop | input | 1 | Closes the current transaction |
| txn_open | output | 1 | A transaction is in progress |
| txn_budget | output | 16 | Allowance latched at the last start |
| host_wr_en | input | 1 | Host byte offered for push |
| host_wr_data | input | 8 | Host push byte |
| host_rd_en | input | 1 | Host requests one byte by pull |
| host_rd_data | output | 8 | Pulled byte |
| host_rd_valid | output | 1 | `host_rd_data` holds a pulled byte |
| int_wr_en | input | 1 | Internal producer write |
| int_wr_data | input | 8 | Internal producer byte |
| int_rd_en | input | 1 | Internal consumer read |
| int_rd_data | output | 8 | Byte delivered to the consumer |
| int_rd_valid | output | 1 | `int_rd_data` holds a delivered byte |
| ctl_wr | input | 1 | Control word write strobe |
| ctl_data | input | 32 | Control word; bit 15 flushes |
| status | output | 32 | Status word |

## Verification
A wrong pointer or count shows up as a wrong status level at the next sample, or as bytes that come out of order. Both are caught by draining the buffer after fills of every depth. A latched allowance that is wrong shows up on `txn_budget` one cycle after the start. Acceptance that does not honour the allowance shows up as a level that differs from the arithmetic value once the host has offered surplus bytes. A sticky flag that is wrong, or a flush that leaks, shows up in bit 3 or the level of `status` in the cycle after the event.

// File: rtl/mbx_pkg.sv
// Shared constants, configuration type and status packing for the mailbox buffer.
// Assumes a 32-bit status word with a 16-bit level field.
package mbx_pkg;

    localparam int STAT_ACTIVE_BIT = 0;
    localparam int STAT_HOST_BIT   = 1;
    localparam int STAT_INPUT_BIT  = 2;
    localparam int STAT_ERR_BIT    = 3;
    localparam int STAT_LEVEL_LSB  = 16;
    localparam int STAT_LEVEL_W    = 16;
    localparam int CTRL_FLUSH_BIT  = 15;
    localparam int WORD_W          = 32;
    localparam int BYTE_W          = 8;

    typedef struct packed {
        logic active;
        logic host_mgd;
        logic is_input;
    } mbx_cfg_t;

    // Assemble the status word from configuration, error flag and level.
    function automatic logic [WORD_W-1:0] pack_status(input mbx_cfg_t cfg,
                                                      input logic err,
                                                      input logic [STAT_LEVEL_W-1:0] lvl);
        logic [WORD_W-1:0] w;
        w = '0;
        w[STAT_ACTIVE_BIT] = cfg.active;
        w[STAT_HOST_BIT]   = cfg.host_mgd;
        w[STAT_INPUT_BIT]  = cfg.is_input;
        w[STAT_ERR_BIT]    = err;
        w[STAT_LEVEL_LSB +: STAT_LEVEL_W] = lvl;
        return w;
    endfunction

endpackage

// File: rtl/mbx_store.sv
// Byte storage with read/write pointers and an occupancy count.
// Writes while full and reads while empty are dropped, and a flush wins over both.
// Read data is registered: rd_data/rd_done are valid the cycle after an accepted read.
module mbx_store #(
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          wr_en,
    input  logic [7:0]    wr_data,
    input  logic          rd_en,
    output logic [7:0]    rd_data,
    output logic          rd_done,
    output logic [AW:0]   count,
    output logic          full,
    output logic          empty
);
    localparam int DEPTH = 1 << AW;
    localparam logic [AW:0] DEPTH_CNT = (AW+1)'(DEPTH);

    logic [7:0]    mem [DEPTH];
    logic [AW-1:0] wr_ptr;
    logic [AW-1:0] rd_ptr;
    logic [AW:0]   count_q;
    logic          wr_ok;
    logic          rd_ok;

    assign full  = (count_q == DEPTH_CNT);
    assign empty = (count_q == '0);
    assign count = count_q;
    assign wr_ok = wr_en && !full && !flush;
    assign rd_ok = rd_en && !empty && !flush;

    // Store an accepted byte at the write pointer.
    always_ff @(posedge clk) begin
        if (wr_ok) begin
            mem[wr_ptr] <= wr_data;
        end
    end

    // Advance the pointers and occupancy, or return them to empty on flush.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr  <= '0;
            rd_ptr  <= '0;
            count_q <= '0;
        end else begin
            if (wr_ok) begin
                wr_ptr <= wr_ptr + 1'b1;
            end
            if (rd_ok) begin
                rd_ptr <= rd_ptr + 1'b1;
            end
            if (wr_ok && !rd_ok) begin
                count_q <= count_q + 1'b1;
            end else if (rd_ok && !wr_ok) begin
                count_q <= count_q - 1'b1;
            end
        end
    end

    // Register the head byte and its valid flag for an accepted read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= '0;
            rd_done <= 1'b0;
        end else begin
            rd_done <= rd_ok;
            if (rd_ok) begin
                rd_data <= mem[rd_ptr];
            end
        end
    end

endmodule

// File: rtl/mbx_txn.sv
// Tracks one host transaction: open flag, direction, the allowance frozen at
// start and the bytes still allowed. Assumes the caller passes the free space
// or the fill level in 'avail' according to the requested direction.
module mbx_txn #(
    parameter int LW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          push_dir,
    input  logic          allowed,
    input  logic [LW-1:0] avail,
    input  logic          take,
    input  logic          stop,
    input  logic          flush,
    output logic          open,
    output logic          is_push,
    output logic [LW-1:0] budget,
    output logic [LW-1:0] left
);
    logic [LW-1:0] grant;

    // The allowance is zero when the access is refused or a flush lands at the start.
    assign grant = (allowed && !flush) ? avail : '0;

    // Open, close and count down the host transaction.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            open    <= 1'b0;
            is_push <= 1'b0;
            budget  <= '0;
            left    <= '0;
        end else if (start) begin
            open    <= 1'b1;
            is_push <= push_dir;
            budget  <= grant;
            left    <= grant;
        end else if (stop) begin
            open <= 1'b0;
            left <= '0;
        end else if (flush) begin
            left <= '0;
        end else if (take && (left != '0)) begin
            left <= left - 1'b1;
        end
    end

endmodule

// File: rtl/mbx_flag.sv
// Sticky error flag: set by an event, cleared by a control write; clear wins.
module mbx_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic flag
);
    // Hold the flag until an explicit clear.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            flag <= 1'b0;
        end else if (set) begin
            flag <= 1'b1;
        end
    end

endmodule

// File: rtl/mbx_buffer.sv
// Directional mailbox buffer. It routes host and internal ports onto one FIFO
// according to the static role settings, applies the per-transaction allowance,
// and builds the status word. Assumes the cfg_* inputs change only in reset.
module mbx_buffer
    import mbx_pkg::*;
#(
    parameter int DEPTH_LOG2 = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_active,
    input  logic        cfg_host_mgd,
    input  logic        cfg_input,
    input  logic        txn_start,
    input  logic        txn_push,
    input  logic        txn_stop,
    output logic        txn_open,
    output logic [15:0] txn_budget,
    input  logic        host_wr_en,
    input  logic [7:0]  host_wr_data,
    input  logic        host_rd_en,
    output logic [7:0]  host_rd_data,
    output logic        host_rd_valid,
    input  logic        int_wr_en,
    input  logic [7:0]  int_wr_data,
    input  logic        int_rd_en,
    output logic [7:0]  int_rd_data,
    output logic        int_rd_valid,
    input  logic        ctl_wr,
    input  logic [31:0] ctl_data,
    output logic [31:0] status
);
    localparam int LVL_W = DEPTH_LOG2 + 1;
    localparam logic [LVL_W-1:0] DEPTH_CNT = LVL_W'(1) << DEPTH_LOG2;

    mbx_cfg_t          cfg;
    logic              wr_from_host;
    logic              rd_to_host;
    logic              flush;
    logic              ctl_hit;
    logic [LVL_W-1:0]  count;
    logic [LVL_W-1:0]  free_sp;
    logic              full;
    logic              empty;
    logic              st_wr_en;
    logic [7:0]        st_wr_data;
    logic              st_rd_en;
    logic [7:0]        st_rd_data;
    logic              st_rd_done;
    logic              t_open;
    logic              t_push;
    logic [LVL_W-1:0]  t_budget;
    logic [LVL_W-1:0]  t_left;
    logic              t_allowed;
    logic [LVL_W-1:0]  t_avail;
    logic              host_take_wr;
    logic              host_take_rd;
    logic              err_set;
    logic              err_q;
    logic [LVL_W-1:0]  level;
    logic [15:0]       txn_left;

    // Collect the static settings and decide which end the host owns.
    always_comb begin
        cfg.active   = cfg_active;
        cfg.host_mgd = cfg_host_mgd;
        cfg.is_input = cfg_input;
        wr_from_host = cfg_host_mgd && cfg_input;
        rd_to_host   = cfg_host_mgd && !cfg_input;
    end

    // Control decode: any write to an active slot hits, bit 15 also flushes.
    always_comb begin
        ctl_hit = ctl_wr && cfg_active;
        flush   = ctl_hit && ctl_data[CTRL_FLUSH_BIT];
    end

    // Transaction admission and the level it would freeze.
    always_comb begin
        free_sp   = DEPTH_CNT - count;
        t_allowed = cfg_active && (txn_push ? wr_from_host : rd_to_host);
        t_avail   = txn_push ? free_sp : count;
    end

    // Host byte acceptance within the open transaction's allowance.
    always_comb begin
        host_take_wr = cfg_active && wr_from_host && t_open && t_push &&
                       (t_left != '0) && host_wr_en;
        host_take_rd = cfg_active && rd_to_host && t_open && !t_push &&
                       (t_left != '0) && host_rd_en;
    end

    // Select the storage write and read sources from the role.
    always_comb begin
        if (wr_from_host) begin
            st_wr_en   = host_take_wr;
            st_wr_data = host_wr_data;
        end else begin
            st_wr_en   = cfg_active && int_wr_en;
            st_wr_data = int_wr_data;
        end
        st_rd_en = rd_to_host ? host_take_rd : (cfg_active && int_rd_en);
    end

    // Peripheral-owned slots flag writes into a full or reads from an empty buffer.
    always_comb begin
        err_set = cfg_active && !cfg_host_mgd &&
                  ((int_wr_en && full) || (int_rd_en && empty));
    end

    mbx_store #(
        .AW(DEPTH_LOG2)
    ) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .flush   (flush),
        .wr_en   (st_wr_en),
        .wr_data (st_wr_data),
        .rd_en   (st_rd_en),
        .rd_data (st_rd_data),
        .rd_done (st_rd_done),
        .count   (count),
        .full    (full),
        .empty   (empty)
    );

    mbx_txn #(
        .LW(LVL_W)
    ) u_txn (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (txn_start),
        .push_dir (txn_push),
        .allowed  (t_allowed),
        .avail    (t_avail),
        .take     (host_take_wr || host_take_rd),
        .stop     (txn_stop),
        .flush    (flush),
        .open     (t_open),
        .is_push  (t_push),
        .budget   (t_budget),
        .left     (t_left)
    );

    mbx_flag u_err (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (err_set),
        .clr   (ctl_hit),
        .flag  (err_q)
    );

    // Drive the outputs: read data fan-out, transaction state and status word.
    always_comb begin
        level         = cfg_input ? free_sp : count;
        host_rd_data  = st_rd_data;
        int_rd_data   = st_rd_data;
        host_rd_valid = st_rd_done && rd_to_host;
        int_rd_valid  = st_rd_done && !rd_to_host;
        txn_open      = t_open;
        txn_budget    = 16'(t_budget);
        txn_left      = 16'(t_left);
        status        = pack_status(cfg, err_q, 16'(level));
    end

endmodule

// File: rtl/mbx_buffer_checker.sv
// Temporal checks on the mailbox buffer, attached to every instance by bind.
module mbx_buffer_checker #(
    parameter int DEPTH_LOG2 = 4
) (
    input logic        clk,
    input logic        rst_n,
    input logic        cfg_active,
    input logic        cfg_host_mgd,
    input logic        cfg_input,
    input logic        txn_start,
    input logic        txn_push,
    input logic [15:0] txn_budget,
    input logic [15:0] txn_left,
    input logic        host_rd_en,
    input logic        host_rd_valid,
    input logic        int_wr_en,
    input logic        int_rd_en,
    input logic        int_rd_valid,
    input logic        ctl_wr,
    input logic [31:0] ctl_data,
    input logic [31:0] status
);
    localparam logic [15:0] DEPTH16 = 16'(1 << DEPTH_LOG2);

    logic [15:0] lvl;
    logic        allowed;
    logic        flushing;
    logic        is_full;
    logic        is_empty;

    // Derive port-level views used by the properties.
    always_comb begin
        lvl      = status[31:16];
        allowed  = cfg_active && cfg_host_mgd && (txn_push ? cfg_input : !cfg_input);
        flushing = ctl_wr && cfg_active && ctl_data[15];
        is_full  = cfg_input ? (lvl == 16'd0) : (lvl == DEPTH16);
        is_empty = cfg_input ? (lvl == DEPTH16) : (lvl == 16'd0);
    end

    assert_level_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        lvl <= DEPTH16);

    assert_budget_frozen_R4: assert property (@(posedge clk) disable iff (!rst_n)
        txn_start && allowed && !flushing |=> txn_budget == $past(lvl));

    assert_left_within_budget_R4: assert property (@(posedge clk) disable iff (!rst_n)
        txn_left <= txn_budget);

    assert_pull_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !host_rd_en |=> !host_rd_valid);

    assert_refused_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        txn_start && !allowed |=> txn_budget == 16'd0);

    assert_flush_empties_R8: assert property (@(posedge clk) disable iff (!rst_n)
        flushing |=> is_empty && !int_rd_valid && !host_rd_valid);

    assert_inactive_still_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_active && $stable(cfg_active) |=> $stable(lvl));

    assert_overflow_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_active && !cfg_host_mgd && !ctl_wr && int_wr_en && is_full |=> status[3]);

    assert_underflow_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_active && !cfg_host_mgd && !ctl_wr && int_rd_en && is_empty |=> status[3]);

    assert_host_no_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_host_mgd |=> !$rose(status[3]));

    assert_ctl_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_wr && cfg_active |=> !status[3]);

endmodule

bind mbx_buffer mbx_buffer_checker #(.DEPTH_LOG2(DEPTH_LOG2)) u_check (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg_active    (cfg_active),
    .cfg_host_mgd  (cfg_host_mgd),
    .cfg_input     (cfg_input),
    .txn_start     (txn_start),
    .txn_push      (txn_push),
    .txn_budget    (txn_budget),
    .txn_left      (txn_left),
    .host_rd_en    (host_rd_en),
    .host_rd_valid (host_rd_valid),
    .int_wr_en     (int_wr_en),
    .int_rd_en     (int_rd_en),
    .int_rd_valid  (int_rd_valid),
    .ctl_wr        (ctl_wr),
    .ctl_data      (ctl_data),
    .status        (status)
);

// File: tb/test_mbx_buffer.sv
module test_mbx_buffer;
    localparam int AW = 3;
    localparam int D  = 1 << AW;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_active = 1'b1, cfg_host_mgd = 1'b1, cfg_input = 1'b1;
    logic        txn_start = 1'b0, txn_push = 1'b0, txn_stop = 1'b0;
    logic        txn_open;
    logic [15:0] txn_budget;
    logic        host_wr_en = 1'b0;
    logic [7:0]  host_wr_data = '0;
    logic        host_rd_en = 1'b0;
    logic [7:0]  host_rd_data;
    logic        host_rd_valid;
    logic        int_wr_en = 1'b0;
    logic [7:0]  int_wr_data = '0;
    logic        int_rd_en = 1'b0;
    logic [7:0]  int_rd_data;
    logic        int_rd_valid;
    logic        ctl_wr = 1'b0;
    logic [31:0] ctl_data = '0;
    logic [31:0] status;

    int checks = 0;
    int errors = 0;
    logic [7:0] got;
    logic       gv;

    always #10 clk = ~clk;

    mbx_buffer #(.DEPTH_LOG2(AW)) i_mbx_buffer (
        .clk(clk), .rst_n(rst_n),
        .cfg_active(cfg_active), .cfg_host_mgd(cfg_host_mgd), .cfg_input(cfg_input),
        .txn_start(txn_start), .txn_push(txn_push), .txn_stop(txn_stop),
        .txn_open(txn_open), .txn_budget(txn_budget),
        .host_wr_en(host_wr_en), .host_wr_data(host_wr_data),
        .host_rd_en(host_rd_en), .host_rd_data(host_rd_data), .host_rd_valid(host_rd_valid),
        .int_wr_en(int_wr_en), .int_wr_data(int_wr_data),
        .int_rd_en(int_rd_en), .int_rd_data(int_rd_data), .int_rd_valid(int_rd_valid),
        .ctl_wr(ctl_wr), .ctl_data(ctl_data), .status(status)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(negedge clk);
    endtask

    task automatic do_reset(input logic a, input logic h, input logic i);
        rst_n = 1'b0;
        cfg_active = a; cfg_host_mgd = h; cfg_input = i;
        repeat (3) cyc();
        rst_n = 1'b1;
    endtask

    task automatic host_push(input logic [7:0] b);
        host_wr_en = 1'b1; host_wr_data = b; cyc(); host_wr_en = 1'b0;
    endtask

    task automatic host_pop();
        host_rd_en = 1'b1; cyc(); host_rd_en = 1'b0;
        got = host_rd_data; gv = host_rd_valid;
    endtask

    task automatic int_push(input logic [7:0] b);
        int_wr_en = 1'b1; int_wr_data = b; cyc(); int_wr_en = 1'b0;
    endtask

    task automatic int_pop();
        int_rd_en = 1'b1; cyc(); int_rd_en = 1'b0;
        got = int_rd_data; gv = int_rd_valid;
    endtask

    task automatic open_txn(input logic dir);
        txn_start = 1'b1; txn_push = dir; cyc(); txn_start = 1'b0;
    endtask

    task automatic close_txn();
        txn_stop = 1'b1; cyc(); txn_stop = 1'b0;
    endtask

    task automatic ctl(input logic [31:0] w);
        ctl_wr = 1'b1; ctl_data = w; cyc(); ctl_wr = 1'b0; ctl_data = '0;
    endtask

    initial begin
        #(20 * 150000);
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        cyc();
        // Host-managed input buffer
        do_reset(1'b1, 1'b1, 1'b1);
        check("R1 R2 status after reset", status, 32'h0008_0007);
        check("R1 txn_open", {31'b0, txn_open}, 32'd0);
        check("R1 txn_budget", {16'b0, txn_budget}, 32'd0);
        for (int k = 0; k <= D; k++) begin
            ctl(32'h0000_8000);
            open_txn(1'b1);
            check("R4 budget on empty", {16'b0, txn_budget}, D);
            for (int j = 0; j < k; j++) host_push(8'(8'h40 + j));
            close_txn();
            check("R3 free level", {16'b0, status[31:16]}, D - k);
            open_txn(1'b1);
            check("R4 budget equals free", {16'b0, txn_budget}, D - k);
            for (int j = 0; j < D; j++) host_push(8'(8'h80 + j));
            check("R4 surplus dropped", {16'b0, status[31:16]}, 32'd0);
            close_txn();
            for (int j = 0; j < D; j++) begin
                int_pop();
                check("R7 consumer order", {23'b0, gv, got},
                      {23'b0, 1'b1, (j < k) ? 8'(8'h40 + j) : 8'(8'h80 + j - k)});
            end
            check("R3 drained level", {16'b0, status[31:16]}, D);
        end
        // Allowance frozen although the consumer frees space mid-transaction
        open_txn(1'b1);
        for (int j = 0; j < 4; j++) host_push(8'(8'h20 + j));
        close_txn();
        open_txn(1'b1);
        check("R4 budget 4", {16'b0, txn_budget}, 32'd4);
        int_pop(); int_pop();
        for (int j = 0; j < 6; j++) host_push(8'(8'h30 + j));
        close_txn();
        check("R4 later space unused", {16'b0, status[31:16]}, 32'd2);
        // Pull on an input buffer
        open_txn(1'b0);
        check("R6 wrong direction budget", {16'b0, txn_budget}, 32'd0);
        host_pop();
        check("R6 no pull data", {31'b0, gv}, 32'd0);
        check("R6 level untouched", {16'b0, status[31:16]}, 32'd2);
        close_txn();
        // Flush with a same-cycle consumer read
        ctl_wr = 1'b1; ctl_data = 32'h0000_8000; int_rd_en = 1'b1; cyc();
        ctl_wr = 1'b0; ctl_data = '0; int_rd_en = 1'b0;
        check("R8 flush beats read", {31'b0, int_rd_valid}, 32'd0);
        check("R8 flush empties", {16'b0, status[31:16]}, D);
        // Flush inside an open push transaction
        open_txn(1'b1);
        for (int j = 0; j < 3; j++) host_push(8'h55);
        ctl(32'h0000_8000);
        for (int j = 0; j < 3; j++) host_push(8'h66);
        check("R8 allowance zeroed", {16'b0, status[31:16]}, D);
        close_txn();
        // Control word without the flush bit
        open_txn(1'b1);
        for (int j = 0; j < 3; j++) host_push(8'h77);
        close_txn();
        ctl(32'h0000_0001);
        check("R11 contents kept", {16'b0, status[31:16]}, 32'd5);

        // Host-managed output buffer
        do_reset(1'b1, 1'b1, 1'b0);
        check("R1 R2 output status", status, 32'h0000_0003);
        for (int k = 0; k <= D; k++) begin
            ctl(32'h0000_8000);
            for (int j = 0; j < k; j++) int_push(8'(8'hC0 + j));
            check("R3 fill level", {16'b0, status[31:16]}, k);
            open_txn(1'b0);
            check("R5 budget equals fill", {16'b0, txn_budget}, k);
            if (k < D) int_push(8'hEE);
            for (int j = 0; j < k + 2; j++) begin
                host_pop();
                check("R5 R7 pulled byte", {23'b0, gv, (j < k) ? got : 8'h00},
                      {23'b0, (j < k), (j < k) ? 8'(8'hC0 + j) : 8'h00});
            end
            check("R5 late data kept", {16'b0, status[31:16]}, (k < D) ? 1 : 0);
            close_txn();
        end
        open_txn(1'b1);
        check("R6 push on output budget", {16'b0, txn_budget}, 32'd0);
        host_push(8'h11);
        check("R6 push on output level", {16'b0, status[31:16]}, 32'd0);
        close_txn();
        for (int j = 0; j <= D; j++) int_push(8'h12);
        check("R10 host-managed no flag", {31'b0, status[3]}, 32'd0);

        // Peripheral-managed output buffer
        do_reset(1'b1, 1'b0, 1'b0);
        check("R2 peripheral status", status, 32'h0000_0001);
        for (int j = 0; j < D; j++) int_push(8'(8'h60 + j));
        check("R10 no flag when filling", {31'b0, status[3]}, 32'd0);
        open_txn(1'b0);
        check("R6 peripheral budget", {16'b0, txn_budget}, 32'd0);
        close_txn();
        int_push(8'hFF);
        check("R10 overflow flag", status, 32'h0008_0009);
        int_push(8'hFF);
        check("R10 sticky", {31'b0, status[3]}, 32'd1);
        ctl(32'h0000_0000);
        check("R11 flag cleared, level kept", status, 32'h0008_0001);
        for (int j = 0; j < D; j++) begin
            int_pop();
            check("R7 peripheral order", {23'b0, gv, got}, {23'b0, 1'b1, 8'(8'h60 + j)});
        end
        int_pop();
        check("R10 underflow flag", {31'b0, gv, status[3]}, 32'd1);

        // Peripheral-managed input buffer
        do_reset(1'b1, 1'b0, 1'b1);
        for (int j = 0; j <= D; j++) int_push(8'h01);
        check("R10 input overflow", status, 32'h0000_000D);

        // Inactive buffer
        do_reset(1'b0, 1'b1, 1'b0);
        check("R2 inactive status", status, 32'h0000_0002);
        for (int j = 0; j < 3; j++) int_push(8'h02);
        check("R9 writes ignored", {16'b0, status[31:16]}, 32'd0);
        ctl(32'h0000_8000);
        check("R9 control ignored", status, 32'h0000_0002);
        open_txn(1'b0);
        check("R6 R9 inactive budget", {16'b0, txn_budget}, 32'd0);
        close_txn();

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule